// File: doc/BRIEF.md
# Data and I/O Breakpoint Matcher

This block watches the data and I/O accesses of a core and compares each one against four programmable breakpoint slots. Each slot holds an address, a 2-bit type field that arms it for writes, for I/O, or for any data access, a 2-bit aligned size code and a local enable. A matching access is not reported at once. It is held until a completion point, and that point depends on what the core is running.

In ordinary execution, hits are held until the accessing instruction completes. During a fast-string operation, they are held until the current group of iterations ends. During a repeated I/O string instruction, they are released at the end of every iteration. As a result, an I/O-port hit appears after the first iteration. A memory hit appears after the iteration that touched the matching address. All slots that matched before a release are reported together on `hit_o`, with one `trap_o` pulse.

Top module: `bkpt_trap_unit`

## Requirements
- R1: `hit_o` carries one bit per slot, with bit i for slot i across the four slots. After reset, `hit_o` is 0 and `trap_o` is 0.
- R2: The access kind `acc_kind_i` is coded as follows: 0 is a data read, 1 is a data write, 2 is an I/O read and 3 is an I/O write. The slot type code 0 never matches. Code 1 matches data writes only. Code 2 matches I/O reads and writes. Code 3 matches data reads and writes.
- R3: A match is held and not reported in the cycle of the access. `trap_o` and `hit_o` rise in the cycle after a release cycle and last one cycle. Held hits are cleared by the release.
- R4: When neither `fast_string_i` nor `rep_io_i` is set, only `insn_done_i` releases held hits.
- R5: With `fast_string_i` set, `iter_done_i` does not release held hits. `group_done_i` releases them, and `insn_done_i` also still releases them.
- R6: With `rep_io_i` set, every `iter_done_i` releases the hits gathered so far, including a match in that same cycle. An iteration without a match raises no trap.
- R7: The exact-match input `exact_en_i` has no effect on matching or reporting.
- R8: A slot whose `slot_en_i` bit is 0 never sets its hit bit.
- R9: When several slots match before one release, all of their bits appear together in `hit_o`, with a single `trap_o`.
- R10: Size codes 0, 1, 2 and 3 cover aligned regions of 1, 2, 4 and 8 bytes. Address bits below the region size are ignored in the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slot_addr_i | input | 4x32 | Breakpoint address per slot |
| slot_type_i | input | 4x2 | Type code per slot (0 off, 1 write, 2 I/O, 3 read/write) |
| slot_size_i | input | 4x2 | Aligned size code per slot |
| slot_en_i | input | 4 | Local enable per slot |
| exact_en_i | input | 2 | Exact-match enables, accepted and ignored |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | 32 | Access address or I/O port |
| acc_kind_i | input | 2 | Access kind |
| fast_string_i | input | 1 | Fast-string operation in progress |
| rep_io_i | input | 1 | Repeated I/O string instruction in progress |
| iter_done_i | input | 1 | Iteration complete strobe |
| insn_done_i | input | 1 | Instruction complete strobe |
| group_done_i | input | 1 | Fast-string group complete strobe |
| hit_o | output | 4 | Per-slot hit bits, valid with trap_o |
| trap_o | output | 1 | Trap request pulse |

## Verification
The bench places a matching access in one cycle and its completion strobe in a later cycle. A design that reported early would show a trap during the access itself. The bench issues iteration strobes during a fast-string run. A design that released on any strobe would trap before the group ends. In repeated I/O mode, the bench precedes the matching iteration with non-matching ones. A design that kept stale hits, or released on the wrong iteration, would trap too soon or report the wrong slot. The bench also checks type 0, a read against a write-only slot, a disabled slot and an address just past a sized region, each of which must stay silent. Toggling the exact-match bits must leave the results unchanged.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned NUM_SLOTS = 4;
  localparam int unsigned ADDR_W    = 32;

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_IO_RD = 2'd2,
    ACC_IO_WR = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    BT_OFF  = 2'd0,
    BT_WR   = 2'd1,
    BT_IO   = 2'd2,
    BT_RW   = 2'd3
  } bkpt_type_e;
endpackage

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
  import bkpt_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] slot_addr_i,
  input  logic [1:0]    slot_type_i,
  input  logic [1:0]    slot_size_i,
  input  logic          slot_en_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [1:0]    acc_kind_i,
  output logic          match_o
);
  logic [AW-1:0] low_mask;
  logic          kind_ok;
  logic          addr_ok;

  assign low_mask = (AW'(1) << slot_size_i) - AW'(1);
  assign addr_ok  = ((slot_addr_i ^ acc_addr_i) & ~low_mask) == '0;

  always_comb begin
    unique case (bkpt_type_e'(slot_type_i))
      BT_WR:   kind_ok = (acc_kind_i == ACC_WR);
      BT_IO:   kind_ok = acc_kind_i[1];
      BT_RW:   kind_ok = !acc_kind_i[1];
      default: kind_ok = 1'b0;
    endcase
  end

  assign match_o = slot_en_i && acc_valid_i && kind_ok && addr_ok;

  always_comb begin
    if (slot_type_i == BT_OFF)
      p_type0_quiet_r2: assert (!match_o);
    if (!slot_en_i)
      p_disabled_quiet_r8: assert (!match_o);
  end
endmodule

// File: rtl/bkpt_hold.sv
module bkpt_hold #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] match_i,
  input  logic         fast_string_i,
  input  logic         rep_io_i,
  input  logic         iter_done_i,
  input  logic         insn_done_i,
  input  logic         group_done_i,
  output logic [N-1:0] hit_o,
  output logic         trap_o
);
  logic [N-1:0] pend_q;
  logic [N-1:0] gathered;
  logic         release_now;

  assign release_now = insn_done_i
                     | (fast_string_i & group_done_i)
                     | (rep_io_i & iter_done_i);
  assign gathered = pend_q | match_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      hit_o  <= '0;
      trap_o <= 1'b0;
    end else if (release_now) begin
      pend_q <= '0;
      hit_o  <= gathered;
      trap_o <= |gathered;
    end else begin
      pend_q <= gathered;
      hit_o  <= '0;
      trap_o <= 1'b0;
    end
  end

  p_trap_after_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(release_now));
  p_release_drains_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_now |=> (pend_q == '0));
  p_group_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_string_i && !rep_io_i && !insn_done_i && !group_done_i) |=> !trap_o);
  p_plain_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_string_i && !rep_io_i && !insn_done_i) |=> !trap_o);
  p_bits_with_trap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o != '0) |-> trap_o);
endmodule

// File: rtl/bkpt_trap_unit.sv
module bkpt_trap_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned N  = NUM_SLOTS,
  parameter int unsigned AW = ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0][AW-1:0] slot_addr_i,
  input  logic [N-1:0][1:0]    slot_type_i,
  input  logic [N-1:0][1:0]    slot_size_i,
  input  logic [N-1:0]         slot_en_i,
  input  logic [1:0]           exact_en_i,
  input  logic                 acc_valid_i,
  input  logic [AW-1:0]        acc_addr_i,
  input  logic [1:0]           acc_kind_i,
  input  logic                 fast_string_i,
  input  logic                 rep_io_i,
  input  logic                 iter_done_i,
  input  logic                 insn_done_i,
  input  logic                 group_done_i,
  output logic [N-1:0]         hit_o,
  output logic                 trap_o
);
  logic [N-1:0] match_vec;
  logic         unused_exact;

  assign unused_exact = ^exact_en_i;  // R7: accepted, no effect

  for (genvar i = 0; i < N; i++) begin : g_slot
    bkpt_slot_cmp #(.AW(AW)) u_cmp (
      .slot_addr_i (slot_addr_i[i]),
      .slot_type_i (slot_type_i[i]),
      .slot_size_i (slot_size_i[i]),
      .slot_en_i   (slot_en_i[i]),
      .acc_valid_i (acc_valid_i),
      .acc_addr_i  (acc_addr_i),
      .acc_kind_i  (acc_kind_i),
      .match_o     (match_vec[i])
    );
  end

  bkpt_hold #(.N(N)) u_hold (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .match_i       (match_vec),
    .fast_string_i (fast_string_i),
    .rep_io_i      (rep_io_i),
    .iter_done_i   (iter_done_i),
    .insn_done_i   (insn_done_i),
    .group_done_i  (group_done_i),
    .hit_o         (hit_o),
    .trap_o        (trap_o)
  );
endmodule

// File: tb/bkpt_trap_unit_tb.sv
module bkpt_trap_unit_tb_top;
  localparam int N  = 4;
  localparam int AW = 32;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [N-1:0][AW-1:0] slot_addr;
  logic [N-1:0][1:0]    slot_type;
  logic [N-1:0][1:0]    slot_size;
  logic [N-1:0]         slot_en;
  logic [1:0]           exact_en;
  logic                 acc_valid;
  logic [AW-1:0]        acc_addr;
  logic [1:0]           acc_kind;
  logic                 fast_string, rep_io, iter_done, insn_done, group_done;
  logic [N-1:0]         hit;
  logic                 trap;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  bkpt_trap_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_addr_i(slot_addr), .slot_type_i(slot_type), .slot_size_i(slot_size),
    .slot_en_i(slot_en), .exact_en_i(exact_en),
    .acc_valid_i(acc_valid), .acc_addr_i(acc_addr), .acc_kind_i(acc_kind),
    .fast_string_i(fast_string), .rep_io_i(rep_io), .iter_done_i(iter_done),
    .insn_done_i(insn_done), .group_done_i(group_done),
    .hit_o(hit), .trap_o(trap)
  );

  task automatic check(input logic [N-1:0] exp_hit, input logic exp_trap, input string req);
    n_checks++;
    if (hit !== exp_hit || trap !== exp_trap) begin
      n_fail++;
      $display("FAIL %s: hit=%b trap=%b expected hit=%b trap=%b", req, hit, trap, exp_hit, exp_trap);
    end
  endtask

  // drive one cycle of stimulus, return after the edge that registers it
  task automatic step(input logic v, input logic [AW-1:0] a, input logic [1:0] k,
                      input logic it, input logic ins, input logic grp);
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_kind = k;
    iter_done = it; insn_done = ins; group_done = grp;
    @(negedge clk);
    acc_valid = 1'b0; iter_done = 1'b0; insn_done = 1'b0; group_done = 1'b0;
  endtask

  task automatic clear_slots();
    for (int i = 0; i < N; i++) begin
      slot_addr[i] = '0; slot_type[i] = 2'd0; slot_size[i] = 2'd0; slot_en[i] = 1'b0;
    end
    fast_string = 1'b0; rep_io = 1'b0;
  endtask

  task automatic set_slot(input int i, input logic [AW-1:0] a, input logic [1:0] t,
                          input logic [1:0] s);
    slot_addr[i] = a; slot_type[i] = t; slot_size[i] = s; slot_en[i] = 1'b1;
  endtask

  task automatic t_reset();
    check('0, 1'b0, "R1 reset");
  endtask

  task automatic t_plain_write(input logic [1:0] ex);
    clear_slots(); exact_en = ex;
    set_slot(0, 32'h1000, 2'd1, 2'd0);
    step(1, 32'h1000, 2'd1, 0, 0, 0);
    check('0, 1'b0, "R3 held during access");
    step(0, 0, 0, 1, 0, 1);
    check('0, 1'b0, "R4 iter/group ignored in plain mode");
    step(0, 0, 0, 0, 1, 0);
    check(4'b0001, 1'b1, ex != 0 ? "R7 exact bits ignored" : "R4 insn release");
    step(0, 0, 0, 0, 0, 0);
    check('0, 1'b0, "R3 one-cycle pulse");
  endtask

  task automatic t_types();
    clear_slots(); exact_en = 2'b00;
    set_slot(0, 32'h2000, 2'd1, 2'd0);  // write only
    set_slot(1, 32'h2000, 2'd0, 2'd0);  // type 0
    set_slot(2, 32'h2000, 2'd2, 2'd0);  // I/O
    step(1, 32'h2000, 2'd0, 0, 1, 0);   // data read
    check('0, 1'b0, "R2 read vs write-only/type0/io");
    step(1, 32'h2000, 2'd3, 0, 1, 0);   // io write
    check(4'b0100, 1'b1, "R2 io write hits type 2 only");
    set_slot(3, 32'h2000, 2'd3, 2'd0);
    step(1, 32'h2000, 2'd0, 0, 1, 0);
    check(4'b1000, 1'b1, "R2 read hits type 3");
  endtask

  task automatic t_disabled();
    clear_slots();
    set_slot(0, 32'h3000, 2'd3, 2'd0);
    slot_en[0] = 1'b0;
    step(1, 32'h3000, 2'd1, 0, 1, 0);
    check('0, 1'b0, "R8 disabled slot");
  endtask

  task automatic t_multi_and_size();
    clear_slots();
    set_slot(0, 32'h100, 2'd3, 2'd2);  // 4 bytes
    set_slot(1, 32'h100, 2'd3, 2'd3);  // 8 bytes
    step(1, 32'h103, 2'd1, 0, 0, 0);
    step(1, 32'h104, 2'd0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    check(4'b0011, 1'b1, "R9 all slots together");
    step(1, 32'h104, 2'd0, 0, 1, 0);
    check(4'b0010, 1'b1, "R10 past 4-byte region");
    step(1, 32'h108, 2'd0, 0, 1, 0);
    check('0, 1'b0, "R10 past 8-byte region");
  endtask

  task automatic t_fast_string();
    clear_slots(); fast_string = 1'b1;
    set_slot(2, 32'h4000, 2'd1, 2'd0);
    step(1, 32'h4000, 2'd1, 1, 0, 0);
    check('0, 1'b0, "R5 iter does not release");
    step(0, 0, 0, 1, 0, 0);
    check('0, 1'b0, "R5 still held");
    step(0, 0, 0, 0, 0, 1);
    check(4'b0100, 1'b1, "R5 group release");
    step(1, 32'h4000, 2'd1, 0, 1, 0);
    check(4'b0100, 1'b1, "R5 insn release");
  endtask

  task automatic t_rep_io();
    clear_slots(); rep_io = 1'b1;
    set_slot(2, 32'h60, 2'd2, 2'd0);
    step(1, 32'h60, 2'd2, 1, 0, 0);
    check(4'b0100, 1'b1, "R6 port hit after first iteration");
    clear_slots(); rep_io = 1'b1;
    set_slot(1, 32'h5008, 2'd3, 2'd0);
    step(1, 32'h5000, 2'd1, 1, 0, 0);
    check('0, 1'b0, "R6 iteration 1 no hit");
    step(1, 32'h5004, 2'd1, 1, 0, 0);
    check('0, 1'b0, "R6 iteration 2 no hit");
    step(1, 32'h5008, 2'd1, 1, 0, 0);
    check(4'b0010, 1'b1, "R6 memory hit at matching iteration");
    step(1, 32'h500c, 2'd1, 1, 0, 0);
    check('0, 1'b0, "R6 no stale hit");
  endtask

  initial begin
    clear_slots();
    exact_en = 2'b00; acc_valid = 0; acc_addr = '0; acc_kind = 0;
    iter_done = 0; insn_done = 0; group_done = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_write(2'b00);
    t_plain_write(2'b11);
    t_types();
    t_disabled();
    t_multi_and_size();
    t_fast_string();
    t_rep_io();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule